// File: doc/BRIEF.md
# Sub-Word Register Window Adapter

This block sits between a host I/O port and a 128-byte register window whose targets accept only full 32-bit accesses. The host may issue byte, halfword or word reads and writes at any byte address. The adapter decodes the address into one of three targets: a file of 8-bit core registers (one per 32-bit slot), a file of 32-bit DMA registers, or a single 32-bit bus/control register. It drives a one-cycle strobe and a register index toward the chosen target.

A write that is narrower than a word, or that is not word aligned, becomes a read-modify-write. The adapter reads the target's current value through its combinational read port, merges the new bytes into it, and issues one 32-bit write at the aligned address. The merge uses the window's own lane placement: the data and the byte mask move left by ((4 - offset) mod 4) bytes, so a byte written at offset 1 lands in the top lane. A read fetches the 32-bit target value, shifts it right by the byte offset, keeps only the requested lanes and returns them one cycle after acceptance. Unmapped addresses read as zero and swallow writes.

Top module: `subword_window_adapter`

## Requirements
- R1: While `rstN` is low, `hostReady`, `respValid` and `respData` are 0 and no strobe fires. From the first rising edge with `rstN` high, `hostReady` is 1.
- R2: An access is accepted in a cycle with `hostValid` and `hostReady` both high. Strobes fire only in an acceptance cycle, and at most one write strobe and at most one read strobe fire in that cycle.
- R3: Byte addresses 0x00-0x3F map to core register `addr[5:2]` and 0x40-0x5F map to DMA register `(addr-0x40)>>2`, both on `regIdx`. A write whose aligned address is 0x70 goes to the control register. A read goes to the control register only at exactly 0x70.
- R4: A word write (size code 2 or 3) at an offset of 0 drives `hostWdata` unchanged on `wrData`.
- R5: The size code gives the access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Any other write is widened. Mask M is the low 8×width bits, and host data bits above the width are ignored. With shift S = ((4-(addr&3))&3)×8, `wrData` = ((data&M)<<S) | (current & ~(M<<S)), truncated to 32 bits.
- R6: The current value for a widened write comes from the core register (zero-extended) below 0x40, from the DMA register for 0x40-0x5F, and from the control register for 0x60-0x73. Above 0x73 it is 0. A core register stores only bits 7:0 of `wrData`.
- R7: A read raises `respValid` for exactly one cycle after the acceptance edge. `respData` = (target value >> 8×(addr&3)) masked to 8×width bits.
- R8: Reads at 0x60-0x6F and 0x71-0x7F return 0 and fire no read strobe. Writes whose aligned address is 0x60-0x6C or 0x74-0x7C fire no write strobe.
- R9: An accepted read to a mapped address fires exactly the read strobe of its target in the acceptance cycle, and a write to a mapped address fires exactly the write strobe of its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request valid |
| hostReady | output | 1 | Adapter can accept a request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 7 | Byte address in the window |
| hostSize | input | 2 | Width code: 0 byte, 1 half, 2/3 word |
| hostWdata | input | 32 | Write data, right-justified |
| respValid | output | 1 | Read data valid |
| respData | output | 32 | Read data, right-justified |
| regIdx | output | 4 | Register index for core or DMA file |
| wrData | output | 32 | Full-word write data to target |
| coreWe | output | 1 | Core register write strobe |
| coreRe | output | 1 | Core register read strobe |
| coreRdata | input | 8 | Core register value at `regIdx` |
| dmaWe | output | 1 | DMA register write strobe |
| dmaRe | output | 1 | DMA register read strobe |
| dmaRdata | input | 32 | DMA register value at `regIdx` |
| ctlWe | output | 1 | Control register write strobe |
| ctlRe | output | 1 | Control register read strobe |
| ctlRdata | input | 32 | Control register value |

## Verification
On every cycle the assertions check that strobes appear only with an accepted request and never more than one per direction. They also check that a response follows each read and only a read, that unmapped reads return zero with unused upper lanes clear, and that addresses past the control register never strobe a write. The merge arithmetic, the unusual lane placement for offset writes, the current-value source per region, the loss of upper bytes into an 8-bit core register and the exact-address rule for control reads all need concrete register contents. Only the bench's vectors can show these, by reading back its own register models after each write.

// File: rtl/swa_pkg.sv
package swa_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_CTL  = 2'd2,
    SRC_ZERO = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    wrCore;
    logic    wrDma;
    logic    wrCtl;
    logic    rdCore;
    logic    rdDma;
    logic    rdCtl;
    logic    widen;
    logic    capture;
    srcSel_e curSrc;
    srcSel_e rdSrc;
  } strobe_t;

  // width code: 0 byte, 1 half, 2/3 word
  function automatic logic [BUS_W-1:0] laneMask(input logic [1:0] sizeCode);
    logic [BUS_W-1:0] m;
    case (sizeCode)
      2'd0:    m = BUS_W'(32'h0000_00FF);
      2'd1:    m = BUS_W'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/swa_ctrl.sv
module swa_ctrl
  import swa_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 4,
  parameter int CORE_END = 64,
  parameter int DMA_END  = 96,
  parameter int CTL_ADDR = 112
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  output logic              hostReady,
  output logic              respValid,
  output logic [IDX_W-1:0]  regIdx,
  output strobe_t           strb
);
  localparam int CTL_END = CTL_ADDR + LANES;
  localparam logic [ADDR_W-1:0] CORE_END_A = ADDR_W'(CORE_END);
  localparam logic [ADDR_W-1:0] DMA_END_A  = ADDR_W'(DMA_END);
  localparam logic [ADDR_W-1:0] CTL_A      = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] CTL_END_A  = ADDR_W'(CTL_END);

  logic readyQ;
  logic accept;
  logic isWrite, isRead;
  logic inCore, inDma, ctlMergeZone;
  logic [ADDR_W-1:0] alignedAddr;
  logic [ADDR_W-1:0] dmaOff;
  logic [OFF_W-1:0]  byteOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      respValid <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      respValid <= accept && !hostWrite;
    end
  end

  assign hostReady   = readyQ;
  assign accept      = hostValid && readyQ;
  assign isWrite     = accept && hostWrite;
  assign isRead      = accept && !hostWrite;
  assign byteOff     = hostAddr[OFF_W-1:0];
  assign alignedAddr = {hostAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // region decode; alignment never moves an address across the core/dma edges
  assign inCore       = hostAddr < CORE_END_A;
  assign inDma        = !inCore && (hostAddr < DMA_END_A);
  assign ctlMergeZone = (hostAddr >= DMA_END_A) && (hostAddr < CTL_END_A);
  assign dmaOff       = hostAddr - CORE_END_A;
  assign regIdx       = inCore ? hostAddr[OFF_W +: IDX_W] : IDX_W'(dmaOff >> OFF_W);

  always_comb begin
    strb         = '0;
    strb.wrCore  = isWrite && inCore;
    strb.wrDma   = isWrite && inDma;
    strb.wrCtl   = isWrite && (alignedAddr == CTL_A);
    strb.rdCore  = isRead && inCore;
    strb.rdDma   = isRead && inDma;
    strb.rdCtl   = isRead && (hostAddr == CTL_A);
    strb.widen   = !hostSize[1] || (byteOff != '0);
    strb.capture = isRead;
    if (inCore)            strb.curSrc = SRC_CORE;
    else if (inDma)        strb.curSrc = SRC_DMA;
    else if (ctlMergeZone) strb.curSrc = SRC_CTL;
    else                   strb.curSrc = SRC_ZERO;
    if (inCore)                  strb.rdSrc = SRC_CORE;
    else if (inDma)              strb.rdSrc = SRC_DMA;
    else if (hostAddr == CTL_A)  strb.rdSrc = SRC_CTL;
    else                         strb.rdSrc = SRC_ZERO;
  end

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> hostReady); // R1
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(hostValid && hostReady) |-> !(strb.wrCore || strb.wrDma || strb.wrCtl ||
                                    strb.rdCore || strb.rdDma || strb.rdCtl)); // R2
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCore, strb.wrDma, strb.wrCtl})); // R2
  AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdCore, strb.rdDma, strb.rdCtl})); // R9
  AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && !hostWrite) |=> respValid); // R7
  AST_NO_RESP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && hostWrite) |=> !respValid); // R7
  AST_HIGH_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrite && hostAddr >= CTL_END_A) |-> !(strb.wrCore || strb.wrDma || strb.wrCtl)); // R8
endmodule

// File: rtl/swa_dpath.sv
module swa_dpath
  import swa_pkg::*;
#(
  parameter int CORE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [OFF_W-1:0] byteOff,
  input  logic [1:0]       hostSize,
  input  logic [BUS_W-1:0] hostWdata,
  input  logic [CORE_W-1:0] coreRdata,
  input  logic [BUS_W-1:0] dmaRdata,
  input  logic [BUS_W-1:0] ctlRdata,
  output logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] respData
);
  localparam int SH_W = OFF_W + 3;

  logic [BUS_W-1:0] coreWide;
  logic [BUS_W-1:0] curVal, rdVal;
  logic [BUS_W-1:0] mask, placedMask, placedData, merged, readOut;
  logic [OFF_W-1:0] leftBytes;
  logic [SH_W-1:0]  leftBits, rightBits;

  assign coreWide = BUS_W'(coreRdata);

  function automatic logic [BUS_W-1:0] pick(input srcSel_e s, input logic [BUS_W-1:0] c,
                                            input logic [BUS_W-1:0] d, input logic [BUS_W-1:0] t);
    case (s)
      SRC_CORE: return c;
      SRC_DMA:  return d;
      SRC_CTL:  return t;
      default:  return '0;
    endcase
  endfunction

  assign curVal = pick(strb.curSrc, coreWide, dmaRdata, ctlRdata);
  assign rdVal  = pick(strb.rdSrc,  coreWide, dmaRdata, ctlRdata);
  assign mask   = laneMask(hostSize);

  // write merge: lanes move left by (LANES - offset) mod LANES bytes
  assign leftBytes  = OFF_W'(LANES) - byteOff;
  assign leftBits   = {leftBytes, 3'b000};
  assign placedMask = mask << leftBits;
  assign placedData = (hostWdata & mask) << leftBits;
  assign merged     = placedData | (curVal & ~placedMask);
  assign wrData     = strb.widen ? merged : hostWdata;

  // read extract: lanes move right by offset bytes
  assign rightBits = {byteOff, 3'b000};
  assign readOut   = (rdVal >> rightBits) & mask;

  always_ff @(posedge clk) begin
    if (!rstN)             respData <= '0;
    else if (strb.capture) respData <= readOut;
  end

  AST_READ_LANES_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (respData & ~$past(mask)) == '0); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.rdSrc == SRC_ZERO) |=> respData == '0); // R8
  AST_RESP_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(respData)); // R7
endmodule

// File: rtl/subword_window_adapter.sv
module subword_window_adapter
  import swa_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 4,
  parameter int CORE_W   = 8,
  parameter int CORE_END = 64,
  parameter int DMA_END  = 96,
  parameter int CTL_ADDR = 112
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [BUS_W-1:0]  hostWdata,
  output logic              respValid,
  output logic [BUS_W-1:0]  respData,
  output logic [IDX_W-1:0]  regIdx,
  output logic [BUS_W-1:0]  wrData,
  output logic              coreWe,
  output logic              coreRe,
  input  logic [CORE_W-1:0] coreRdata,
  output logic              dmaWe,
  output logic              dmaRe,
  input  logic [BUS_W-1:0]  dmaRdata,
  output logic              ctlWe,
  output logic              ctlRe,
  input  logic [BUS_W-1:0]  ctlRdata
);
  strobe_t strb;

  swa_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_END(CORE_END),
    .DMA_END(DMA_END), .CTL_ADDR(CTL_ADDR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostReady(hostReady),
    .respValid(respValid), .regIdx(regIdx), .strb(strb)
  );

  swa_dpath #(.CORE_W(CORE_W)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteOff(hostAddr[OFF_W-1:0]),
    .hostSize(hostSize), .hostWdata(hostWdata), .coreRdata(coreRdata),
    .dmaRdata(dmaRdata), .ctlRdata(ctlRdata), .wrData(wrData), .respData(respData)
  );

  assign coreWe = strb.wrCore;
  assign dmaWe  = strb.wrDma;
  assign ctlWe  = strb.wrCtl;
  assign coreRe = strb.rdCore;
  assign dmaRe  = strb.rdDma;
  assign ctlRe  = strb.rdCtl;
endmodule

// File: tb/subword_window_adapter_test.sv
module subword_window_adapter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 1'b0, hostWrite = 1'b0;
  logic [6:0] hostAddr = '0;
  logic [1:0] hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic hostReady, respValid;
  logic [31:0] respData, wrData;
  logic [3:0] regIdx;
  logic coreWe, coreRe, dmaWe, dmaRe, ctlWe, ctlRe;
  logic [7:0] coreRdata;
  logic [31:0] dmaRdata, ctlRdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  subword_window_adapter uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .respValid(respValid), .respData(respData),
    .regIdx(regIdx), .wrData(wrData), .coreWe(coreWe), .coreRe(coreRe),
    .coreRdata(coreRdata), .dmaWe(dmaWe), .dmaRe(dmaRe), .dmaRdata(dmaRdata),
    .ctlWe(ctlWe), .ctlRe(ctlRe), .ctlRdata(ctlRdata)
  );

  // target register models
  logic [7:0]  coreMem [16];
  logic [31:0] dmaMem  [8];
  logic [31:0] ctlReg;
  assign coreRdata = coreMem[regIdx];
  assign dmaRdata  = dmaMem[regIdx[2:0]];
  assign ctlRdata  = ctlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) coreMem[i] <= 8'h10 + 8'(i);
      for (int i = 0; i < 8; i++)  dmaMem[i]  <= 32'h1122_3344;
      ctlReg <= 32'hCAFE_F00D;
    end else begin
      if (coreWe) coreMem[regIdx] <= wrData[7:0];
      if (dmaWe)  dmaMem[regIdx[2:0]] <= wrData;
      if (ctlWe)  ctlReg <= wrData;
    end
  end

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // tgt: 0 core, 1 dma, 2 ctl, 3 none. exp: read data, or target value after write
  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [1:0]  tgt;
    logic [3:0]  idx;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 7'h40, 32'h0,         2'd1, 4'd0, 32'h1122_3344, 4'd3},  // R3 word read dma0
    '{1'b0, 2'd0, 7'h41, 32'h0,         2'd1, 4'd0, 32'h0000_0033, 4'd7},  // R7 byte at offset 1
    '{1'b0, 2'd1, 7'h42, 32'h0,         2'd1, 4'd0, 32'h0000_1122, 4'd7},  // R7 half at offset 2
    '{1'b0, 2'd0, 7'h0C, 32'h0,         2'd0, 4'd3, 32'h0000_0013, 4'd3},  // R3 core3
    '{1'b0, 2'd0, 7'h0D, 32'h0,         2'd0, 4'd3, 32'h0000_0000, 4'd6},  // R6 core zero-extended
    '{1'b1, 2'd0, 7'h44, 32'h0000_00AB, 2'd1, 4'd1, 32'h1122_33AB, 4'd5},  // R5 byte offset 0
    '{1'b1, 2'd0, 7'h49, 32'h0000_005A, 2'd1, 4'd2, 32'h5A22_3344, 4'd5},  // R5 byte offset 1 -> top lane
    '{1'b1, 2'd1, 7'h4E, 32'h0000_BEEF, 2'd1, 4'd3, 32'hBEEF_3344, 4'd5},  // R5 half offset 2
    '{1'b1, 2'd0, 7'h53, 32'h0000_0077, 2'd1, 4'd4, 32'h1122_7744, 4'd5},  // R5 byte offset 3
    '{1'b1, 2'd1, 7'h57, 32'h0000_1234, 2'd1, 4'd5, 32'h1112_3444, 4'd5},  // R5 half offset 3
    '{1'b1, 2'd2, 7'h58, 32'hDEAD_BEEF, 2'd1, 4'd6, 32'hDEAD_BEEF, 4'd4},  // R4 aligned word
    '{1'b1, 2'd3, 7'h5D, 32'h9988_77C3, 2'd1, 4'd7, 32'hC322_3344, 4'd5},  // R5 word misaligned, truncated
    '{1'b1, 2'd0, 7'h05, 32'h0000_0066, 2'd0, 4'd1, 32'h0000_0011, 4'd6},  // R6 core keeps low byte only
    '{1'b1, 2'd0, 7'h08, 32'h0000_01F5, 2'd0, 4'd2, 32'h0000_00F5, 4'd5},  // R5 upper data ignored
    '{1'b1, 2'd0, 7'h71, 32'h0000_005B, 2'd2, 4'd0, 32'h5BFE_F00D, 4'd6},  // R6 ctl supplies current
    '{1'b0, 2'd2, 7'h70, 32'h0,         2'd2, 4'd0, 32'h5BFE_F00D, 4'd3},  // R3 ctl read
    '{1'b0, 2'd0, 7'h71, 32'h0,         2'd3, 4'd0, 32'h0000_0000, 4'd8},  // R8 ctl only at exact addr
    '{1'b0, 2'd2, 7'h60, 32'h0,         2'd3, 4'd0, 32'h0000_0000, 4'd8},  // R8 hole read
    '{1'b1, 2'd2, 7'h64, 32'h1234_5678, 2'd3, 4'd0, 32'h0000_0000, 4'd8},  // R8 hole write
    '{1'b0, 2'd1, 7'h4A, 32'h0,         2'd1, 4'd2, 32'h0000_5A22, 4'd7},  // R7 readback of merged
    '{1'b0, 2'd0, 7'h08, 32'h0,         2'd0, 4'd2, 32'h0000_00F5, 4'd9}   // R9 core read strobe
  };

  task automatic runVec(input vec_t v);
    logic [5:0] seen, want;
    logic [31:0] got;
    @(negedge clk);
    hostValid = 1'b1; hostWrite = v.wr; hostAddr = v.addr;
    hostSize = v.sz; hostWdata = v.data;
    #1;
    seen = {coreWe, dmaWe, ctlWe, coreRe, dmaRe, ctlRe};
    want = '0;
    if (v.tgt != 2'd3) want[v.wr ? (5 - int'(v.tgt)) : (2 - int'(v.tgt))] = 1'b1;
    // R9 strobe pattern, R2 single strobe
    check(seen == want, 9, "strobes", 32'(seen), 32'(want));
    if (v.tgt == 2'd0 || v.tgt == 2'd1)
      check(regIdx == v.idx, 3, "regIdx", 32'(regIdx), 32'(v.idx));
    @(negedge clk);
    hostValid = 1'b0;
    if (v.wr) begin
      case (v.tgt)
        2'd0: got = 32'(coreMem[v.idx]);
        2'd1: got = dmaMem[v.idx[2:0]];
        2'd2: got = ctlReg;
        default: got = 32'h0;
      endcase
      if (v.tgt != 2'd3) check(got == v.exp, int'(v.req), "target after write", got, v.exp);
      check(respValid == 1'b0, 7, "no response to write", 32'(respValid), 32'h0);
    end else begin
      check(respValid == 1'b1, 7, "respValid", 32'(respValid), 32'h1);
      check(respData == v.exp, int'(v.req), "read data", respData, v.exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = 7'h40; hostSize = 2'd2;
    #1;
    check(hostReady == 1'b0, 1, "hostReady in reset", 32'(hostReady), 32'h0);
    check(respValid == 1'b0, 1, "respValid in reset", 32'(respValid), 32'h0);
    check(respData == 32'h0, 1, "respData in reset", respData, 32'h0);
    check({coreWe, dmaWe, ctlWe} == 3'b000, 1, "no strobe in reset", 32'({coreWe, dmaWe, ctlWe}), 32'h0);
    hostValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady == 1'b1, 1, "hostReady after reset", 32'(hostReady), 32'h1);

    // table walk
    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R7 response lasts one cycle
    @(negedge clk);
    check(respValid == 1'b0, 7, "respValid drops", 32'(respValid), 32'h0);

    // R2 no strobe without valid
    hostWrite = 1'b1; hostAddr = 7'h44; hostSize = 2'd2; hostWdata = 32'h5555_5555;
    #1;
    check({coreWe, dmaWe, ctlWe, coreRe, dmaRe, ctlRe} == 6'b0, 2, "idle strobes",
          32'({coreWe, dmaWe, ctlWe, coreRe, dmaRe, ctlRe}), 32'h0);
    @(negedge clk);
    check(dmaMem[1] == 32'h1122_33AB, 2, "idle leaves dma1", dmaMem[1], 32'h1122_33AB);

    // R4 aligned word write drives data unchanged on wrData
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = 7'h44; hostSize = 2'd2; hostWdata = 32'hA5A5_0F0F;
    #1;
    check(wrData == 32'hA5A5_0F0F, 4, "wrData pass", wrData, 32'hA5A5_0F0F);
    @(negedge clk);
    hostValid = 1'b0;

    // R8 write past control register (aligned 0x74) has no effect
    hostValid = 1'b1; hostWrite = 1'b1; hostAddr = 7'h76; hostSize = 2'd0; hostWdata = 32'hFF;
    #1;
    check({coreWe, dmaWe, ctlWe} == 3'b0, 8, "high write strobes", 32'({coreWe, dmaWe, ctlWe}), 32'h0);
    @(negedge clk);
    hostValid = 1'b0;
    check(ctlReg == 32'h5BFE_F00D, 8, "ctl untouched", ctlReg, 32'h5BFE_F00D);

    // R5 back-to-back reads: halfword at offset 1 of dma3
    hostValid = 1'b1; hostWrite = 1'b0; hostAddr = 7'h4D; hostSize = 2'd1;
    @(negedge clk);
    hostAddr = 7'h3C; hostSize = 2'd2;
    check(respData == 32'h0000_EF33, 7, "half at offset 1", respData, 32'h0000_EF33);
    @(negedge clk);
    hostValid = 1'b0;
    check(respValid && respData == 32'h0000_001F, 7, "core15 word read", respData, 32'h0000_001F);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule